// File: doc/BRIEF.md
# Radix-4 Booth Partial Product Generator

This combinational block forms one row of a radix-4 signed multiplier. It takes a signed multiplicand `y_op`, a signed multiplier `x_op` and a group index `grp_sel`. It picks the overlapping three-bit window of the multiplier that belongs to that group and recodes it into a signed digit in the range -2 to +2. It then produces the digit-times-multiplicand partial product. The row is one bit wider than the operand and is held in true two's complement. The output is also sign-extended to four bits beyond the operand width, so an adder tree can shift and accumulate it directly.

Negation happens entirely inside the generator. The magnitude row is inverted, and the negate flag is rippled into it through a chain of half adders. A downstream adder therefore never has to inject a correction bit.

The extension sign comes from the signs of the operands rather than from the top bit of the row. This keeps the one overflowing case (most negative multiplicand times digit -2, giving +2^W) correct in the wide output.

The select signals and the unextended row are brought out for observation. The block has no clock and no state, so there is no handshake: every output follows its inputs combinationally. Summing the rows and any pipelining are left to the surrounding multiplier.

Top module: `booth_pp_gen`

## Requirements
- R1: Group k reads the window made of multiplier bits 2k+1 (most significant), 2k and 2k-1. Bit -1 is a constant 0, so group 0 uses {x[1], x[0], 0}.
- R2: `sel_neg` equals the window's most significant bit. `sel_one` equals the XOR of its two lower bits. `sel_two` is 1 only for windows 100 and 011. `sel_one` and `sel_two` are never both 1.
- R3: The digit given by the selects is (`sel_one` ? 1 : `sel_two` ? 2 : 0), negated when `sel_neg` is 1. The windows map as follows: 000→0, 001→+1, 010→+1, 011→+2, 100→-2, 101→-1, 110→-1, 111→0.
- R4: `pp_raw` (W+1 bits) equals digit × Y modulo 2^(W+1). For negative digits this is the complete two's complement, with the +1 already applied.
- R5: For windows 000 and 111, `pp_raw` and `pp_ext` are both all zeros, even though window 111 sets `sel_neg`.
- R6: `pp_ext` (W+4 bits), read as a signed number, equals digit × Y for every operand pair and every group. This includes Y = -2^(W-1) with digit -2, whose result is +2^W.
- R7: Bits W+1 and above of `pp_ext` all equal the sign of the true product digit × Y. They are 0 whenever that product is zero or positive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| y_op | input | W (8) | Signed multiplicand |
| x_op | input | W (8) | Signed multiplier whose windows are recoded |
| grp_sel | input | clog2(W/2) (2) | Group index k, 0 to W/2-1 |
| pp_ext | output | W+4 (12) | Sign-extended partial product, digit × Y |
| pp_raw | output | W+1 (9) | Two's-complement partial product before extension |
| sel_neg | output | 1 | Negate select of the recoded digit |
| sel_one | output | 1 | Single-magnitude select |
| sel_two | output | 1 | Double-magnitude select |

## Verification
The bench builds the block with its default width W = 8, giving four groups and a 12-bit output. At this size the full input space is 256 × 256 × 4 combinations, and the bench sweeps all of it. Expected digits and products are computed with plain integer arithmetic from the window bits. Every window therefore meets every multiplicand, including the zero multiplicand with a negative digit and the most-negative multiplicand with digit -2.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Recoded radix-4 digit as three one-hot-ish selects.
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_sel_t;

  // Window bits ordered {msb, mid, lsb}.
  function automatic booth_sel_t booth_recode(input logic [2:0] win);
    booth_sel_t s;
    s.neg = win[2];
    s.one = win[1] ^ win[0];
    s.two = (win[2] & ~win[1] & ~win[0]) | (~win[2] & win[1] & win[0]);
    return s;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
#(
  parameter int W      = 8,
  parameter int GSEL_W = 2
) (
  input  logic [W-1:0]      x_op,
  input  logic [GSEL_W-1:0] grp_sel,
  output booth_sel_t        sel
);

  localparam int PAD_W = W + 1;

  logic [PAD_W-1:0] x_pad;
  logic [2:0]       win;

  always_comb begin
    // Implicit bit -1 is zero.
    x_pad = {x_op, 1'b0};
    win   = x_pad[{grp_sel, 1'b0} +: 3];
    sel   = booth_recode(win);
    AST_SEL_EXCLUSIVE: assert (!(sel.one && sel.two))
      else $error("one and two selects both set"); // R2
  end

endmodule

// File: rtl/booth_half_adder.sv
module booth_half_adder (
  input  logic a,
  input  logic b,
  output logic s,
  output logic c
);

  assign s = a ^ b;
  assign c = a & b;

endmodule

// File: rtl/booth_row_decoder.sv
module booth_row_decoder
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] y_op,
  input  booth_sel_t   sel,
  output logic [W:0]   raw
);

  localparam int RAW_W = W + 1;

  logic [RAW_W-1:0] y_sx;    // multiplicand sign-extended by one bit
  logic [RAW_W-1:0] y_dn;    // multiplicand shifted up one (bit j holds y_sx[j-1])
  logic [RAW_W-1:0] inv_row; // selected magnitude xor negate
  logic [RAW_W-1:0] carry;   // half-adder carry chain, seeded by negate

  assign y_sx     = {y_op[W-1], y_op};
  assign y_dn     = {y_sx[RAW_W-2:0], 1'b0};
  assign carry[0] = sel.neg;

  for (genvar j = 0; j < RAW_W; j++) begin : g_bit
    assign inv_row[j] = ((y_sx[j] & sel.one) | (y_dn[j] & sel.two)) ^ sel.neg;
    if (j < RAW_W - 1) begin : g_ha
      booth_half_adder u_ha (
        .a (inv_row[j]),
        .b (carry[j]),
        .s (raw[j]),
        .c (carry[j+1])
      );
    end else begin : g_top
      assign raw[j] = inv_row[j] ^ carry[j];
    end
  end

  always_comb begin
    if (!(sel.one || sel.two)) begin
      AST_IDLE_ROW_ZERO: assert (raw == '0)
        else $error("zero digit left a nonzero row"); // R5
    end
    if (sel.neg && sel.one) begin
      AST_NEG_ONE_TWOS: assert (raw == RAW_W'(~y_sx + 1'b1))
        else $error("negated single row is not two's complement"); // R4
    end
    if (sel.neg && sel.two) begin
      AST_NEG_TWO_TWOS: assert (raw == RAW_W'(~y_dn + 1'b1))
        else $error("negated double row is not two's complement"); // R4
    end
  end

endmodule

// File: rtl/booth_sign_ext.sv
module booth_sign_ext
  import booth_pkg::*;
#(
  parameter int W     = 8,
  parameter int OUT_W = W + 4
) (
  input  logic [W:0]       raw,
  input  logic [W-1:0]     y_op,
  input  booth_sel_t       sel,
  output logic [OUT_W-1:0] pp_ext
);

  localparam int EXT_W = OUT_W - W - 1;

  logic y_nz;
  logic mag;
  logic sgn;

  always_comb begin
    y_nz   = |y_op;
    mag    = sel.one | sel.two;
    // True product sign: survives the +2^W overflow of the narrow row.
    sgn    = mag & y_nz & (sel.neg ^ y_op[W-1]);
    pp_ext = {{EXT_W{sgn}}, raw};
    if (raw == '0) begin
      AST_ZERO_CLEAN: assert (pp_ext == '0)
        else $error("stray sign on zero row"); // R5
    end
    if (raw[W] != pp_ext[OUT_W-1]) begin
      AST_SIGN_ONLY_OVF: assert (raw == {1'b1, {W{1'b0}}})
        else $error("extension sign differs outside overflow case"); // R6
    end
  end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_pkg::*;
#(
  parameter  int W      = 8,
  localparam int GROUPS = W / 2,
  localparam int GSEL_W = $clog2(GROUPS),
  localparam int RAW_W  = W + 1,
  localparam int OUT_W  = W + 4
) (
  input  logic [W-1:0]      y_op,
  input  logic [W-1:0]      x_op,
  input  logic [GSEL_W-1:0] grp_sel,
  output logic [OUT_W-1:0]  pp_ext,
  output logic [RAW_W-1:0]  pp_raw,
  output logic              sel_neg,
  output logic              sel_one,
  output logic              sel_two
);

  booth_sel_t sel;

  booth_recoder #(.W(W), .GSEL_W(GSEL_W)) u_rec (
    .x_op    (x_op),
    .grp_sel (grp_sel),
    .sel     (sel)
  );

  booth_row_decoder #(.W(W)) u_dec (
    .y_op (y_op),
    .sel  (sel),
    .raw  (pp_raw)
  );

  booth_sign_ext #(.W(W), .OUT_W(OUT_W)) u_ext (
    .raw    (pp_raw),
    .y_op   (y_op),
    .sel    (sel),
    .pp_ext (pp_ext)
  );

  assign sel_neg = sel.neg;
  assign sel_one = sel.one;
  assign sel_two = sel.two;

endmodule

// File: tb/sim_booth_pp_gen.sv
`timescale 1ns/1ps
module sim_booth_pp_gen;

  localparam int W     = 8;
  localparam int LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  y_op = '0;
  logic [7:0]  x_op = '0;
  logic [1:0]  grp_sel = '0;
  logic [11:0] pp_ext;
  logic [8:0]  pp_raw;
  logic        sel_neg, sel_one, sel_two;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  booth_pp_gen #(.W(W)) u0 (
    .y_op(y_op), .x_op(x_op), .grp_sel(grp_sel),
    .pp_ext(pp_ext), .pp_raw(pp_raw),
    .sel_neg(sel_neg), .sel_one(sel_one), .sel_two(sel_two)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s x=%0d y=%0d g=%0d actual=%0d expected=%0d",
               tag, x_op, y_op, grp_sel, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset-time state: all-zero inputs give a zero row (R5).
    check(pp_ext == 12'd0, "R5 idle", int'(pp_ext), 0);
    check(pp_raw == 9'd0,  "R5 idle raw", int'(pp_raw), 0);

    for (int g = 0; g < 4; g++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          int win, b2, b1, b0, digit, ys, prod, e_one, e_two, d_sel;
          grp_sel = 2'(g);
          x_op    = 8'(x);
          y_op    = 8'(y);
          #1;
          win   = ((x << 1) >> (2 * g)) & 7;
          b2    = (win >> 2) & 1;
          b1    = (win >> 1) & 1;
          b0    = win & 1;
          digit = -2 * b2 + b1 + b0;
          ys    = (y > 127) ? y - 256 : y;
          prod  = digit * ys;
          e_one = b1 ^ b0;
          e_two = (win == 4 || win == 3) ? 1 : 0;
          // R1: negate follows multiplier bit 2k+1 (bit -1 = 0 for group 0)
          check(int'(sel_neg) == ((x >> (2 * g + 1)) & 1), "R1", int'(sel_neg),
                (x >> (2 * g + 1)) & 1);
          // R2: select encoding and exclusivity
          check(int'(sel_one) == e_one && int'(sel_two) == e_two && !(sel_one && sel_two),
                "R2", {sel_one, sel_two}, e_one * 2 + e_two);
          // R3: digit implied by the selects
          d_sel = sel_one ? 1 : (sel_two ? 2 : 0);
          if (sel_neg) d_sel = -d_sel;
          check(d_sel == digit, "R3", d_sel, digit);
          // R4: raw row modulo 2^9, negatives fully complemented
          check(int'(pp_raw) == (prod & 511), "R4", int'(pp_raw), prod & 511);
          // R5: zero windows give all-zero outputs
          if (win == 0 || win == 7)
            check(pp_ext == 12'd0 && pp_raw == 9'd0, "R5", int'(pp_ext), 0);
          // R6: full signed value, incl. -128 * -2 = +256
          check(int'($signed(pp_ext)) == prod, "R6", int'($signed(pp_ext)), prod);
          // R7: extension bits equal the true product sign
          check(pp_ext[11:9] == ((prod < 0) ? 3'b111 : 3'b000), "R7",
                int'(pp_ext[11:9]), (prod < 0) ? 7 : 0);
          #1;
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule